// File: doc/BRIEF.md
# Duplicated Multiplier with Shifted-Recompute Fault Diagnosis

This block is an unsigned multiplier built to keep delivering correct products when one of its two combinational copies carries a permanent fault, such as a flipped configuration cell that turns a node into a stuck-at. Both copies multiply the same operands every cycle, and each keeps its result in its own sample register. A comparator watches the two samples. While they agree, products flow to a three-slot output register with a two-cycle latency and no stall.

When the samples disagree, the block spends one hold cycle on diagnosis. Both copies recompute the stored operand pair with each operand doubled, so the same physical fault lands on a different product bit. The result is scaled back down by four, and each copy compares it with its own stored sample. A copy whose two answers differ is marked faulty. From then on, the third output slot follows the healthy copy, so the bitwise majority of the three slots outvotes the faulty one. This choice stays in force until a clear input, which models a configuration scrub, returns the block to its default state.

A pair of fault-emulation inputs can force one raw product bit of either copy. This lets a permanent fault be exercised from the ports.

Top module: `dup_mult_guard`

## Requirements
- R1: Each operand pair accepted at a clock edge with `hold_o` low appears as `a_i*b_i` on `prod_o` after the next edge at which `hold_o` is low. Without a hold, this is two edges.
- R2: While the two sample registers agree, `hold_o` stays low. This includes runs with an emulated fault that does not change the product.
- R3: When the samples disagree and no diagnosis has yet run since reset or clear, `hold_o` is high for exactly one cycle. Operands presented in that cycle are not accepted and must be presented again.
- R4: `prod_o` does not change at the edge that ends a hold cycle.
- R5: During diagnosis, each copy multiplies the stored operands, each shifted left by one bit, then shifts the product right by two bits. The copy is flagged faulty when this differs from its own stored sample. `flt_o[0]` reports copy 0 and `flt_o[1]` reports copy 1.
- R6: Output slot 0 is fed by copy 0 and slot 1 by copy 1. Slot 2 is fed by copy 0 by default, and by copy 1 after a diagnosis that flags only copy 0. With a single faulty copy, every product on `prod_o` is correct, including the one whose mismatch triggered diagnosis.
- R7: After a diagnosis, `hold_o` stays low until `clr_i`, whatever the samples do.
- R8: When both copies fail the check, or both pass it, `unres_o` rises, `flt_o` shows both check results, and slot 2 stays on copy 0.
- R9: `clr_i` high at an edge clears `flt_o` and `unres_o`, returns slot 2 to copy 0, and re-arms diagnosis. `clr_i` takes priority over a diagnosis in the same cycle.
- R10: `prod_o` is the bitwise majority of the three output slots.
- R11: After reset, `prod_o`, `hold_o`, `flt_o` and `unres_o` are all zero.
- R12: `emu_flt_en_i[i]` forces bit `emu_flt_bit_i` of copy i's raw (2W+2)-bit product to `emu_flt_val_i[i]`. The force applies in both normal and diagnosis computations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| clr_i | input | 1 | Clear diagnosis state (scrub event) |
| emu_flt_en_i | input | 2 | Per-copy fault emulation enable |
| emu_flt_bit_i | input | $clog2(2W+2) | Raw product bit forced by emulation |
| emu_flt_val_i | input | 2 | Per-copy forced value |
| prod_o | output | 2W | Voted product |
| hold_o | output | 1 | Diagnosis cycle: inputs not accepted, output held |
| flt_o | output | 2 | Per-copy faulty flag |
| unres_o | output | 1 | Diagnosis could not single out one copy |

## Verification
A wrong selection latch shows up as a wrong product on `prod_o` at the first accepting edge after diagnosis, whenever the faulty copy is the one the latch picked. A stuck or mistimed diagnosis state shows up at `hold_o` within a cycle: a missing stall, a second stall, or a hold that repeats. The hold also shifts the product stream, which the scoreboard notices one item later. Corrupt flag state is visible directly on `flt_o` and `unres_o` one cycle after the hold, and again after each clear.

// File: rtl/dmul_pkg.sv
package dmul_pkg;

    typedef enum logic {
        ST_WATCH = 1'b0,
        ST_DONE  = 1'b1
    } dmul_st_e;

    typedef struct packed {
        dmul_st_e   st;
        logic       sel;
        logic [1:0] flt;
        logic       unres;
    } dmul_diag_s;

    localparam dmul_diag_s DIAG_IDLE = '{st: ST_WATCH, sel: 1'b0, flt: 2'b00, unres: 1'b0};

endpackage

// File: rtl/dmul_copy.sv
module dmul_copy #(
    parameter  int W  = 8,
    localparam int PW = 2 * W,
    localparam int XW = W + 1,
    localparam int RW = 2 * XW,
    localparam int BW = $clog2(RW)
) (
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic          recheck_i,
    input  logic [PW-1:0] samp_i,
    input  logic          flt_en_i,
    input  logic [BW-1:0] flt_bit_i,
    input  logic          flt_val_i,
    output logic [PW-1:0] prod_o,
    output logic          bad_o
);

    logic [XW-1:0] oa;
    logic [XW-1:0] ob;
    logic [RW-1:0] raw;
    logic [RW-1:0] raw_f;
    logic [PW-1:0] rec;

    // operand encoder: normal or doubled
    always_comb begin
        if (recheck_i) begin
            oa = {a_i, 1'b0};
            ob = {b_i, 1'b0};
        end else begin
            oa = {1'b0, a_i};
            ob = {1'b0, b_i};
        end
    end

    assign raw = RW'(oa) * RW'(ob);

    // permanent-fault emulation on one raw product node
    for (genvar k = 0; k < RW; k++) begin : g_node
        assign raw_f[k] = (flt_en_i && (flt_bit_i == BW'(k))) ? flt_val_i : raw[k];
    end

    assign prod_o = raw_f[PW-1:0];
    assign rec    = raw_f[RW-1:2];
    assign bad_o  = recheck_i && (rec != samp_i);

endmodule

// File: rtl/dmul_diag.sv
module dmul_diag
    import dmul_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mis_i,
    input  logic [1:0] bad_i,
    input  logic       clr_i,
    output logic       hold_o,
    output logic       sel_o,
    output logic [1:0] flt_o,
    output logic       unres_o
);

    dmul_diag_s dg_d;
    dmul_diag_s dg_q;
    logic       hold;

    always_comb begin
        hold = (dg_q.st == ST_WATCH) && mis_i;
        dg_d = dg_q;
        if (clr_i) begin
            dg_d = DIAG_IDLE;
        end else if (hold) begin
            dg_d.st    = ST_DONE;
            dg_d.flt   = bad_i;
            dg_d.unres = (bad_i[0] == bad_i[1]);
            dg_d.sel   = (bad_i == 2'b01);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dg_q <= DIAG_IDLE;
        else        dg_q <= dg_d;
    end

    assign hold_o  = hold;
    assign sel_o   = dg_q.sel;
    assign flt_o   = dg_q.flt;
    assign unres_o = dg_q.unres;

    // R2
    a_r2_no_stall_on_agree: assert property (@(posedge clk) disable iff (!rst_n)
        !mis_i |-> !hold_o);
    // R3
    a_r3_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o && !clr_i) |=> !hold_o);
    // R7
    a_r7_no_rediag: assert property (@(posedge clk) disable iff (!rst_n)
        (dg_q.st == ST_DONE && !clr_i) |=> !hold_o);
    // R8
    a_r8_unres_keeps_default: assert property (@(posedge clk) disable iff (!rst_n)
        unres_o |-> !sel_o);
    // R9
    a_r9_clear_restores: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (flt_o == 2'b00 && !unres_o && !sel_o));
    // R7
    a_r7_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (dg_q.st == ST_DONE && !clr_i) |=> $stable(flt_o));

endmodule

// File: rtl/dmul_vote.sv
module dmul_vote #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [PW-1:0] s0_i,
    input  logic [PW-1:0] s1_i,
    input  logic          sel_i,
    output logic [PW-1:0] prod_o
);

    typedef struct packed {
        logic [PW-1:0] t0;
        logic [PW-1:0] t1;
        logic [PW-1:0] t2;
    } slots_s;

    slots_s tr_d;
    slots_s tr_q;

    always_comb begin
        tr_d = tr_q;
        if (load_i) begin
            tr_d.t0 = s0_i;
            tr_d.t1 = s1_i;
            tr_d.t2 = sel_i ? s1_i : s0_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tr_q <= '0;
        else        tr_q <= tr_d;
    end

    assign prod_o = (tr_q.t0 & tr_q.t1) | (tr_q.t0 & tr_q.t2) | (tr_q.t1 & tr_q.t2);

    // R10
    a_r10_pair_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_q.t1 == tr_q.t2) |-> (prod_o == tr_q.t1));

endmodule

// File: rtl/dup_mult_guard.sv
module dup_mult_guard #(
    parameter  int W  = 8,
    localparam int PW = 2 * W,
    localparam int BW = $clog2(2 * W + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic          clr_i,
    input  logic [1:0]    emu_flt_en_i,
    input  logic [BW-1:0] emu_flt_bit_i,
    input  logic [1:0]    emu_flt_val_i,
    output logic [PW-1:0] prod_o,
    output logic          hold_o,
    output logic [1:0]    flt_o,
    output logic          unres_o
);

    typedef struct packed {
        logic [W-1:0]  opa;
        logic [W-1:0]  opb;
        logic [PW-1:0] s0;
        logic [PW-1:0] s1;
    } smp_s;

    smp_s          sr_d;
    smp_s          sr_q;
    logic          hold;
    logic          mis;
    logic          sel;
    logic [W-1:0]  mul_a;
    logic [W-1:0]  mul_b;
    logic [PW-1:0] cp   [2];
    logic [PW-1:0] smp  [2];
    logic [1:0]    bad;

    assign smp[0] = sr_q.s0;
    assign smp[1] = sr_q.s1;
    assign mis    = (sr_q.s0 != sr_q.s1);

    // during diagnosis the copies see the stored pair
    assign mul_a = hold ? sr_q.opa : a_i;
    assign mul_b = hold ? sr_q.opb : b_i;

    for (genvar g = 0; g < 2; g++) begin : g_copy
        dmul_copy #(.W(W)) u_copy (
            .a_i       (mul_a),
            .b_i       (mul_b),
            .recheck_i (hold),
            .samp_i    (smp[g]),
            .flt_en_i  (emu_flt_en_i[g]),
            .flt_bit_i (emu_flt_bit_i),
            .flt_val_i (emu_flt_val_i[g]),
            .prod_o    (cp[g]),
            .bad_o     (bad[g])
        );
    end

    always_comb begin
        sr_d = sr_q;
        if (!hold) begin
            sr_d.opa = a_i;
            sr_d.opb = b_i;
            sr_d.s0  = cp[0];
            sr_d.s1  = cp[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    dmul_diag u_diag (
        .clk     (clk),
        .rst_n   (rst_n),
        .mis_i   (mis),
        .bad_i   (bad),
        .clr_i   (clr_i),
        .hold_o  (hold),
        .sel_o   (sel),
        .flt_o   (flt_o),
        .unres_o (unres_o)
    );

    dmul_vote #(.PW(PW)) u_vote (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (!hold),
        .s0_i   (sr_q.s0),
        .s1_i   (sr_q.s1),
        .sel_i  (sel),
        .prod_o (prod_o)
    );

    assign hold_o = hold;

    // R4
    a_r4_output_held: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |=> $stable(prod_o));
    // R3
    a_r3_samples_kept: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |=> ($stable(sr_q.s0) && $stable(sr_q.s1)));

endmodule

// File: tb/sim_dup_mult_guard.sv
`timescale 1ns/1ps
module sim_dup_mult_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  a_i = '0;
    logic [7:0]  b_i = '0;
    logic        clr_i = 1'b0;
    logic [1:0]  emu_flt_en_i = '0;
    logic [4:0]  emu_flt_bit_i = '0;
    logic [1:0]  emu_flt_val_i = '0;
    logic [15:0] prod_o;
    logic        hold_o;
    logic [1:0]  flt_o;
    logic        unres_o;

    always #4 clk = ~clk;

    dup_mult_guard #(.W(8)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .a_i           (a_i),
        .b_i           (b_i),
        .clr_i         (clr_i),
        .emu_flt_en_i  (emu_flt_en_i),
        .emu_flt_bit_i (emu_flt_bit_i),
        .emu_flt_val_i (emu_flt_val_i),
        .prod_o        (prod_o),
        .hold_o        (hold_o),
        .flt_o         (flt_o),
        .unres_o       (unres_o)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    int          hold_cnt = 0;
    bit          mon_on = 1'b0;
    bit          skip = 1'b1;
    bit          hold_prev = 1'b0;
    logic [15:0] prod_prev = '0;
    logic [15:0] expq [$];
    logic [1:0]  f_en = '0;
    logic [4:0]  f_bit = '0;
    logic [1:0]  f_val = '0;
    logic [31:0] seed = 32'h1234_5678;

    task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: one accepted operand pair per call
    task automatic send(input logic [7:0] a, input logic [7:0] b,
                        input logic [15:0] exp, input logic do_clr);
        @(negedge clk);
        while (hold_o) @(negedge clk);
        a_i           = a;
        b_i           = b;
        clr_i         = do_clr;
        emu_flt_en_i  = f_en;
        emu_flt_bit_i = f_bit;
        emu_flt_val_i = f_val;
        expq.push_back(exp);
    endtask

    task automatic send_rand();
        logic [7:0] a;
        logic [7:0] b;
        seed = seed * 32'd1103515245 + 32'd12345;
        a = seed[23:16];
        b = seed[31:24];
        send(a, b, 16'(a) * 16'(b), 1'b0);
    endtask

    // monitor: pops one expected product per accepting edge
    always @(negedge clk) begin
        if (mon_on) begin
            if (!hold_prev) begin
                if (skip) skip = 1'b0;
                else if (expq.size() > 0) expect_eq("R1/R6 product", 32'(prod_o), 32'(expq.pop_front()));
            end else begin
                expect_eq("R4 product held", 32'(prod_o), 32'(prod_prev));
            end
            if (hold_o) hold_cnt++;
            hold_prev = hold_o;
            prod_prev = prod_o;
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired, run incomplete (all requirements)");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        expect_eq("R11 prod", 32'(prod_o), 0);
        expect_eq("R11 hold", 32'(hold_o), 0);
        expect_eq("R11 flt", 32'(flt_o), 0);
        expect_eq("R11 unres", 32'(unres_o), 0);
        rst_n = 1'b1;
        expq.push_back(16'd0);
        @(posedge clk);
        mon_on = 1'b1;

        // R1 R10: fault-free stream, corners and pseudo-random
        send(8'd0, 8'd0, 16'd0, 1'b0);
        send(8'd255, 8'd255, 16'd65025, 1'b0);
        send(8'd1, 8'd255, 16'd255, 1'b0);
        send(8'd128, 8'd2, 16'd256, 1'b0);
        send(8'd15, 8'd17, 16'd255, 1'b0);
        for (int i = 0; i < 30; i++) send_rand();
        expect_eq("R2 no stall fault-free", 32'(hold_cnt), 0);

        // R2 R12: stuck-0 on bit 4 of copy 1, products with bit 4 clear
        f_en = 2'b10; f_bit = 5'd4; f_val = 2'b00;
        send(8'd0, 8'd9, 16'd0, 1'b0);
        send(8'd1, 8'd1, 16'd1, 1'b0);
        send(8'd2, 8'd3, 16'd6, 1'b0);
        send(8'd3, 8'd5, 16'd15, 1'b0);
        f_en = 2'b00;
        send(8'd7, 8'd7, 16'd49, 1'b0);
        expect_eq("R2 masked fault no stall", 32'(hold_cnt), 0);
        expect_eq("R2 flags idle", 32'(flt_o), 0);

        // R3 R5 R6: stuck-1 on bit 3 of copy 0
        f_en = 2'b01; f_bit = 5'd3; f_val = 2'b01;
        send(8'd0, 8'd5, 16'd0, 1'b0);
        send(8'd6, 8'd7, 16'd42, 1'b0);
        expect_eq("R3 one stall", 32'(hold_cnt), 1);
        expect_eq("R5 copy0 flagged", 32'(flt_o), 32'b01);
        expect_eq("R8 resolved", 32'(unres_o), 0);
        for (int i = 0; i < 20; i++) send_rand();
        expect_eq("R7 no further stall", 32'(hold_cnt), 1);

        // R9: scrub and clear
        f_en = 2'b00;
        send(8'd9, 8'd9, 16'd81, 1'b1);
        send(8'd2, 8'd2, 16'd4, 1'b0);
        expect_eq("R9 flags cleared", 32'(flt_o), 0);
        expect_eq("R9 unres cleared", 32'(unres_o), 0);

        // R5 R6: stuck-1 on bit 0 of copy 1 (bit lost by the right shift)
        f_en = 2'b10; f_bit = 5'd0; f_val = 2'b10;
        send(8'd2, 8'd3, 16'd6, 1'b0);
        send(8'd5, 8'd5, 16'd25, 1'b0);
        expect_eq("R9 rearmed stall", 32'(hold_cnt), 2);
        expect_eq("R5 copy1 flagged", 32'(flt_o), 32'b10);
        for (int i = 0; i < 10; i++) send_rand();

        // R8: both copies fail the check, default slot kept (5 = copy0 result)
        f_en = 2'b00;
        send(8'd3, 8'd3, 16'd9, 1'b1);
        send(8'd4, 8'd4, 16'd16, 1'b0);
        f_en = 2'b11; f_bit = 5'd2; f_val = 2'b01;
        send(8'd1, 8'd1, 16'd5, 1'b0);
        f_en = 2'b00;
        send(8'd6, 8'd6, 16'd36, 1'b0);
        expect_eq("R8 unresolved", 32'(unres_o), 1);
        expect_eq("R8 both flagged", 32'(flt_o), 32'b11);
        expect_eq("R3 stall count", 32'(hold_cnt), 3);
        send(8'd2, 8'd9, 16'd18, 1'b0);
        for (int i = 0; i < 3; i++) send(8'd0, 8'd0, 16'd0, 1'b0);
        expect_eq("R7 final stall count", 32'(hold_cnt), 3);
        @(negedge clk);
        finish_run();
    end

endmodule